// File: doc/BRIEF.md
# Time-Ordered Event Filter

This block sits at the centre of a multi-crate acquisition system. Several concentrator streams deliver fixed-width 352-bit hit records over valid/ready handshakes. Each stream lands in a small FIFO of its own. A merge stage then picks the oldest head record across all streams, so that one stream of non-decreasing timestamps enters the filter. A record must also survive a chain of filter checks before it leaves on the valid/ready output toward the network exporter.

The filter checks are a per-type keep mask, an optional shield veto, per-type thinning (one record in N), and a gate built from up to fourteen programmable coincidence conditions. The veto and the gate look back over a short history of recent records that passed the mask. All settings are static input vectors that are changed only while the block is idle. The block takes at most one record per cycle.

Top module: `event_time_filter`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is low, every `in_ready` bit is high, the look-back history is empty and every thinning counter is zero.
- R2: Each input FIFO holds FIFO_DEPTH records. `in_ready[i]` is low exactly when FIFO i holds FIFO_DEPTH records. A record is stored when `in_valid[i]` and `in_ready[i]` are both high at a clock edge.
- R3: The timestamp is record bits [47:0]. When every FIFO has a head, the merge forwards the head with the smallest timestamp, one record per cycle.
- R4: If two or more heads share the smallest timestamp, the head of the lowest-numbered input is forwarded first.
- R5: If at least one FIFO has a head and at least one is empty, the merge holds until a wait counter reaches TIMEOUT. The counter counts the cycles in that state and is cleared when a record is forwarded or when all FIFOs are empty. The merge then forwards the smallest head that is present.
- R6: The detector type is record bits [51:48]. A record whose bit in `type_mask` is 0 is discarded and does not enter the look-back history. Every other forwarded record enters the history, which keeps the HIST most recent entries.
- R7: While `supp_en` is high, a record whose type differs from `shield_type` is discarded if the history holds a `shield_type` entry whose timestamp is no more than `veto_win[type]` below its own. The window fields are 16 bits each, and type t uses bits [16t+15:16t].
- R8: Each type has a counter that advances on every record of that type that passes R6 and R7. The counter wraps after `ds_factor[type]` steps (8-bit fields, type t at [8t+7:8t]). A record passes only when its counter was zero. A factor of 0 or 1 passes every record.
- R9: Condition c counts the record itself plus the history entries whose type bit is set in `cond_types[16c+15:16c]` and whose timestamp lies within `cond_win[16c+15:16c]` below the record's own. The record itself counts only when its own type bit is set. The condition is met when this count is at least `cond_mult[4c+3:4c]`. A record that passes R8 is emitted if any condition enabled in `cond_en` is met, or if `cond_en` is zero.
- R10: An accepted record appears on `out_data` with `out_valid` in the cycle after it is forwarded. It stays unchanged while `out_ready` is low. A new record is forwarded only when the output register is empty or is being drained in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | NUM_IN | Per-stream record valid |
| in_ready | output | NUM_IN | Per-stream FIFO has room |
| in_data | input | NUM_IN*EVT_W | Stream records, stream i at [EVT_W*i +: EVT_W] |
| type_mask | input | 16 | Keep bit per detector type |
| supp_en | input | 1 | Shield veto enable |
| shield_type | input | 4 | Detector type treated as shield |
| veto_win | input | 16*WIN_W | Veto window per record type |
| ds_factor | input | 16*DS_W | Thinning factor per type |
| cond_en | input | NCOND | Condition enable bits |
| cond_types | input | NCOND*16 | Type set per condition |
| cond_mult | input | NCOND*MULT_W | Minimum count per condition |
| cond_win | input | NCOND*WIN_W | Time window per condition |
| out_valid | output | 1 | Accepted record valid |
| out_ready | input | 1 | Downstream accepts |
| out_data | output | EVT_W | Accepted record |

## Verification
A corrupted history entry or thinning counter shows at the ports in a limited way. It does not disturb the record being filtered at the time. It changes the accept decision of the next record whose type or window touches that entry, one cycle after that record is forwarded. A wrong merge pick or a wrong wait count shows at once: a record leaves out of timestamp order, or leaves early or late by a known number of cycles. The reference model compares `in_ready`, `out_valid` and `out_data` on every cycle, so each such fault is caught within a cycle of its first visible effect.

// File: rtl/evf_pkg.sv
`timescale 1ns/1ps
// Shared field positions of the raw hit record.
package evf_pkg;
    localparam int TS_W   = 48;             // timestamp field, bits [47:0]
    localparam int TY_W   = 4;              // detector type, bits [51:48]
    localparam int NTYPES = 1 << TY_W;
    localparam int KEY_W  = TS_W + TY_W;    // part of the record the filter reads
endpackage

// File: rtl/evf_fifo.sv
`timescale 1ns/1ps
// evf_fifo: per-stream record buffer.
// Assumes DEPTH is a power of two. Ready reflects the stored count only.
module evf_fifo #(
    parameter int W     = 352,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_valid,
    output logic         wr_ready,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic         rd_nempty,
    output logic [W-1:0] rd_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    assign wr_ready  = (cnt != CW'(DEPTH));
    assign rd_nempty = (cnt != '0);
    assign rd_data   = mem[rp];
    assign do_wr     = wr_valid && wr_ready;
    assign do_rd     = rd_en && rd_nempty;

    // Storage write, no reset needed.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_wr && !do_rd)      cnt <= cnt + 1'b1;
            else if (!do_wr && do_rd) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/evf_merge.sv
`timescale 1ns/1ps
// evf_merge: picks the oldest FIFO head. Ties go to the lowest index.
// Holds while some stream is empty, up to TIMEOUT cycles.
module evf_merge import evf_pkg::*; #(
    parameter int NUM_IN  = 4,
    parameter int W       = 352,
    parameter int TIMEOUT = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IN*W-1:0] heads,
    input  logic [NUM_IN-1:0]   nempty,
    input  logic                m_ready,
    output logic                m_valid,
    output logic [W-1:0]        m_data,
    output logic [NUM_IN-1:0]   pop
);
    localparam int WC_W = $clog2(TIMEOUT + 1) > 0 ? $clog2(TIMEOUT + 1) : 1;

    logic [WC_W-1:0]   wait_cnt;
    logic [NUM_IN-1:0] sel;
    logic [TS_W-1:0]   best_ts;
    logic              found, any_ne, all_ne, released, take;

    // Smallest-timestamp search; strict compare keeps the lower index on ties.
    always_comb begin
        sel     = '0;
        best_ts = '0;
        found   = 1'b0;
        m_data  = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (nempty[i] && (!found || heads[i*W +: TS_W] < best_ts)) begin
                found   = 1'b1;
                best_ts = heads[i*W +: TS_W];
                sel     = '0;
                sel[i]  = 1'b1;
                m_data  = heads[i*W +: W];
            end
        end
    end

    assign any_ne   = |nempty;
    assign all_ne   = &nempty;
    assign released = all_ne || (wait_cnt == WC_W'(TIMEOUT));
    assign m_valid  = any_ne && released;
    assign take     = m_valid && m_ready;
    assign pop      = take ? sel : '0;

    // Wait counter for partially filled inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)                     wait_cnt <= '0;
        else if (!any_ne || take)       wait_cnt <= '0;
        else if (!all_ne && wait_cnt != WC_W'(TIMEOUT))
                                        wait_cnt <= wait_cnt + 1'b1;
    end
endmodule

// File: rtl/evf_filter.sv
`timescale 1ns/1ps
// evf_filter: mask, shield veto, thinning and coincidence gate on one record.
// Keeps a history of the last HIST kept records. Assumes the input is time-ordered.
module evf_filter import evf_pkg::*; #(
    parameter int HIST   = 8,
    parameter int NCOND  = 14,
    parameter int WIN_W  = 16,
    parameter int DS_W   = 8,
    parameter int MULT_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [KEY_W-1:0]          cur,
    input  logic                      take,
    input  logic [NTYPES-1:0]         type_mask,
    input  logic                      supp_en,
    input  logic [TY_W-1:0]           shield_type,
    input  logic [NTYPES*WIN_W-1:0]   veto_win,
    input  logic [NTYPES*DS_W-1:0]    ds_factor,
    input  logic [NCOND-1:0]          cond_en,
    input  logic [NCOND*NTYPES-1:0]   cond_types,
    input  logic [NCOND*MULT_W-1:0]   cond_mult,
    input  logic [NCOND*WIN_W-1:0]    cond_win,
    output logic                      accept
);
    localparam int CNT_W = $clog2(HIST + 2);

    logic [TS_W-1:0] h_ts [HIST];
    logic [TY_W-1:0] h_ty [HIST];
    logic [HIST-1:0] h_v;
    logic [DS_W-1:0] ds_cnt [NTYPES];
    logic [TS_W-1:0] cur_ts;
    logic [TY_W-1:0] cur_ty;
    logic            keep, veto, ds_ok, gate_ok;
    logic [NCOND-1:0] met;
    logic [DS_W:0]   ds_inc;

    assign cur_ts = cur[TS_W-1:0];
    assign cur_ty = cur[KEY_W-1:TS_W];

    function automatic logic near(input logic [TS_W-1:0] now, input logic [TS_W-1:0] old,
                                  input logic [WIN_W-1:0] win);
        logic [TS_W-1:0] d;
        d = now - old;
        return d <= TS_W'(win);
    endfunction

    // Shield veto search over the history.
    always_comb begin
        veto = 1'b0;
        if (supp_en && cur_ty != shield_type)
            for (int h = 0; h < HIST; h++)
                if (h_v[h] && h_ty[h] == shield_type &&
                    near(cur_ts, h_ts[h], veto_win[cur_ty*WIN_W +: WIN_W]))
                    veto = 1'b1;
    end

    // One multiplicity counter per coincidence condition.
    for (genvar c = 0; c < NCOND; c++) begin : g_cond
        logic [CNT_W-1:0] n;
        always_comb begin
            n = CNT_W'(cond_types[c*NTYPES + int'(cur_ty)]);
            for (int h = 0; h < HIST; h++)
                if (h_v[h] && cond_types[c*NTYPES + int'(h_ty[h])] &&
                    near(cur_ts, h_ts[h], cond_win[c*WIN_W +: WIN_W]))
                    n = n + 1'b1;
        end
        assign met[c] = int'(n) >= int'(cond_mult[c*MULT_W +: MULT_W]);
    end

    assign keep    = type_mask[cur_ty];
    assign ds_ok   = (ds_cnt[cur_ty] == '0);
    assign gate_ok = (cond_en == '0) || |(cond_en & met);
    assign accept  = keep && !veto && ds_ok && gate_ok;
    assign ds_inc  = {1'b0, ds_cnt[cur_ty]} + 1'b1;

    // History shift register of kept records.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_v <= '0;
        end else if (take && keep) begin
            h_v <= {h_v[HIST-2:0], 1'b1};
        end
    end

    // History payload, no reset needed (guarded by h_v).
    always_ff @(posedge clk) begin
        if (take && keep) begin
            h_ts[0] <= cur_ts;
            h_ty[0] <= cur_ty;
            for (int h = 1; h < HIST; h++) begin
                h_ts[h] <= h_ts[h-1];
                h_ty[h] <= h_ty[h-1];
            end
        end
    end

    // Per-type thinning counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NTYPES; t++) ds_cnt[t] <= '0;
        end else if (take && keep && !veto) begin
            ds_cnt[cur_ty] <= (ds_inc >= {1'b0, ds_factor[cur_ty*DS_W +: DS_W]})
                              ? '0 : ds_inc[DS_W-1:0];
        end
    end
endmodule

// File: rtl/event_time_filter.sv
`timescale 1ns/1ps
// event_time_filter: buffers each stream, merges the streams in time order
// and filters into one registered valid/ready output.
// Assumes the configuration inputs change only while the block is idle.
module event_time_filter import evf_pkg::*; #(
    parameter int NUM_IN     = 4,
    parameter int EVT_W      = 352,
    parameter int FIFO_DEPTH = 4,
    parameter int TIMEOUT    = 16,
    parameter int HIST       = 8,
    parameter int NCOND      = 14,
    parameter int WIN_W      = 16,
    parameter int DS_W       = 8,
    parameter int MULT_W     = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IN-1:0]         in_valid,
    output logic [NUM_IN-1:0]         in_ready,
    input  logic [NUM_IN*EVT_W-1:0]   in_data,
    input  logic [NTYPES-1:0]         type_mask,
    input  logic                      supp_en,
    input  logic [TY_W-1:0]           shield_type,
    input  logic [NTYPES*WIN_W-1:0]   veto_win,
    input  logic [NTYPES*DS_W-1:0]    ds_factor,
    input  logic [NCOND-1:0]          cond_en,
    input  logic [NCOND*NTYPES-1:0]   cond_types,
    input  logic [NCOND*MULT_W-1:0]   cond_mult,
    input  logic [NCOND*WIN_W-1:0]    cond_win,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [EVT_W-1:0]          out_data
);
    logic [NUM_IN*EVT_W-1:0] heads;
    logic [NUM_IN-1:0]       nempty, pop;
    logic                    m_valid, m_ready, take, accept;
    logic [EVT_W-1:0]        m_data;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        evf_fifo #(.W(EVT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_valid (in_valid[i]),
            .wr_ready (in_ready[i]),
            .wr_data  (in_data[i*EVT_W +: EVT_W]),
            .rd_en    (pop[i]),
            .rd_nempty(nempty[i]),
            .rd_data  (heads[i*EVT_W +: EVT_W])
        );
    end

    evf_merge #(.NUM_IN(NUM_IN), .W(EVT_W), .TIMEOUT(TIMEOUT)) u_merge (
        .clk(clk), .rst_n(rst_n), .heads(heads), .nempty(nempty),
        .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data), .pop(pop)
    );

    assign m_ready = !out_valid || out_ready;
    assign take    = m_valid && m_ready;

    evf_filter #(.HIST(HIST), .NCOND(NCOND), .WIN_W(WIN_W), .DS_W(DS_W),
                 .MULT_W(MULT_W)) u_filter (
        .clk(clk), .rst_n(rst_n), .cur(m_data[KEY_W-1:0]), .take(take),
        .type_mask(type_mask), .supp_en(supp_en), .shield_type(shield_type),
        .veto_win(veto_win), .ds_factor(ds_factor), .cond_en(cond_en),
        .cond_types(cond_types), .cond_mult(cond_mult), .cond_win(cond_win),
        .accept(accept)
    );

    // Output register: load accepted record, clear when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (take && accept) begin
            out_valid <= 1'b1;
            out_data  <= m_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/evf_checker.sv
`timescale 1ns/1ps
// evf_checker: temporal properties of event_time_filter, attached by bind.
module evf_checker #(
    parameter int NUM_IN = 4,
    parameter int EVT_W  = 352
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [EVT_W-1:0]  out_data,
    input logic [15:0]       type_mask,
    input logic              take,
    input logic              accept,
    input logic [3:0]        m_type,
    input logic [NUM_IN-1:0] pop
);
    // R10: a stalled output keeps its record.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R10: output only becomes valid after an accepted forward.
    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(take && accept));

    // R3: at most one stream is drained per cycle.
    assert_single_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));

    // R6: masked-out types are never accepted.
    assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take && accept |-> type_mask[m_type]);
endmodule

bind event_time_filter evf_checker #(.NUM_IN(NUM_IN), .EVT_W(EVT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .type_mask(type_mask), .take(take), .accept(accept),
    .m_type(m_data[51:48]), .pop(pop)
);

// File: tb/event_time_filter_tb.sv
`timescale 1ns/1ps
module event_time_filter_tb;
    localparam int NI = 4, W = 352, D = 4, TO = 16, HIST = 8, NC = 14, NT = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [NI-1:0]   in_valid = '0, in_ready;
    logic [NI*W-1:0] in_data = '0;
    logic [NT-1:0]   tmask;
    logic            supp_en;
    logic [3:0]      shield;
    logic [15:0]     vw   [NT];
    logic [7:0]      dsf  [NT];
    logic [NC-1:0]   cen;
    logic [15:0]     cty  [NC];
    logic [3:0]      cmul [NC];
    logic [15:0]     cwin [NC];
    logic [NT*16-1:0] vw_f;
    logic [NT*8-1:0]  dsf_f;
    logic [NC*16-1:0] cty_f, cwin_f;
    logic [NC*4-1:0]  cmul_f;
    logic            out_valid, out_ready = 1'b1;
    logic [W-1:0]    out_data;

    always_comb begin
        for (int t = 0; t < NT; t++) begin
            vw_f[t*16 +: 16] = vw[t];
            dsf_f[t*8 +: 8]  = dsf[t];
        end
        for (int c = 0; c < NC; c++) begin
            cty_f[c*16 +: 16]  = cty[c];
            cwin_f[c*16 +: 16] = cwin[c];
            cmul_f[c*4 +: 4]   = cmul[c];
        end
    end

    event_time_filter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .type_mask(tmask), .supp_en(supp_en),
        .shield_type(shield), .veto_win(vw_f), .ds_factor(dsf_f),
        .cond_en(cen), .cond_types(cty_f), .cond_mult(cmul_f), .cond_win(cwin_f),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int errors = 0, checks = 0, cyc = 0, serial = 0;
    string cur_req = "R1";
    bit hold_out = 0;

    // stimulus queues
    logic [W-1:0] pend [NI][64];
    int pend_n [NI], pend_h [NI];

    // reference model state
    logic [W-1:0] mf [NI][D];
    int mfc [NI];
    int mwait = 0;
    bit m_ov = 0;
    logic [W-1:0] m_od = '0;
    logic [51:0] mhist [$];
    int mds [NT];

    task automatic check(bit ok, string req, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d: got %h expected %h", req, cyc, got, exp);
        end
    endtask

    task automatic add(int i, int ty, longint ts);
        logic [W-1:0] ev = '0;
        serial++;
        ev[47:0]    = ts[47:0];
        ev[51:48]   = ty[3:0];
        ev[351:320] = serial;
        ev[100:69]  = ~serial;
        pend[i][pend_n[i]] = ev;
        pend_n[i]++;
    endtask

    // behavioural filter decision with history and thinning side effects
    task automatic model_filter(logic [W-1:0] ev, output bit acc);
        int ty = int'(ev[51:48]);
        logic [47:0] ts = ev[47:0];
        bit keep = tmask[ty], veto = 0, gate = 0, dsok;
        if (supp_en && ty != int'(shield))
            foreach (mhist[k])
                if (mhist[k][51:48] == shield && (ts - mhist[k][47:0]) <= 48'(vw[ty]))
                    veto = 1;
        dsok = (mds[ty] == 0);
        if (cen == '0) gate = 1;
        for (int c = 0; c < NC; c++) begin
            int n = cty[c][ty] ? 1 : 0;
            foreach (mhist[k])
                if (cty[c][mhist[k][51:48]] && (ts - mhist[k][47:0]) <= 48'(cwin[c]))
                    n++;
            if (cen[c] && n >= int'(cmul[c])) gate = 1;
        end
        acc = keep && !veto && dsok && gate;
        if (keep && !veto) mds[ty] = (mds[ty] + 1 >= int'(dsf[ty])) ? 0 : mds[ty] + 1;
        if (keep) begin
            mhist.push_front(ev[51:0]);
            if (mhist.size() > HIST) void'(mhist.pop_back());
        end
    endtask

    task automatic step();
        bit any = 0, all = 1, mv, take, acc = 0;
        bit rdy [NI];
        int sel = -1;
        logic [W-1:0] ev;
        @(negedge clk);
        cyc++;
        for (int i = 0; i < NI; i++)
            check(in_ready[i] === (mfc[i] < D), "R2", W'(in_ready[i]), W'(mfc[i] < D));
        check(out_valid === m_ov, cur_req, W'(out_valid), W'(m_ov));
        if (m_ov) check(out_data === m_od, cur_req, out_data, m_od);
        for (int i = 0; i < NI; i++) begin
            in_valid[i] = pend_h[i] < pend_n[i];
            in_data[i*W +: W] = in_valid[i] ? pend[i][pend_h[i]] : '0;
        end
        out_ready = hold_out ? (cyc % 5 == 0) : 1'b1;
        for (int i = 0; i < NI; i++) begin
            rdy[i] = mfc[i] < D;
            if (mfc[i] > 0) begin
                any = 1;
                if (sel < 0 || mf[i][0][47:0] < mf[sel][0][47:0]) sel = i;
            end else all = 0;
        end
        mv   = any && (all || mwait >= TO);
        take = mv && (!m_ov || out_ready);
        if (take) begin
            ev = mf[sel][0];
            model_filter(ev, acc);
            for (int k = 0; k < D - 1; k++) mf[sel][k] = mf[sel][k+1];
            mfc[sel]--;
        end
        if (take && acc) begin m_ov = 1; m_od = ev; end
        else if (out_ready) m_ov = 0;
        if (!any || take) mwait = 0;
        else if (!all && mwait < TO) mwait++;
        for (int i = 0; i < NI; i++)
            if (in_valid[i] && rdy[i]) begin
                mf[i][mfc[i]] = pend[i][pend_h[i]];
                mfc[i]++;
                pend_h[i]++;
            end
    endtask

    function automatic bit busy();
        bit b = m_ov;
        for (int i = 0; i < NI; i++) if (pend_h[i] < pend_n[i] || mfc[i] > 0) b = 1;
        return b;
    endfunction

    task automatic drain();
        while (busy()) step();
        repeat (3) step();
        for (int i = 0; i < NI; i++) begin pend_n[i] = 0; pend_h[i] = 0; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        tmask = '1; supp_en = 0; shield = 4'd7; cen = '0;
        for (int t = 0; t < NT; t++) begin vw[t] = 0; dsf[t] = 1; mds[t] = 0; end
        for (int c = 0; c < NC; c++) begin cty[c] = 0; cmul[c] = 0; cwin[c] = 0; end
        for (int i = 0; i < NI; i++) begin mfc[i] = 0; pend_n[i] = 0; pend_h[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0, "R1", W'(out_valid), '0);
        check(in_ready === '1, "R1", W'(in_ready), W'(4'hF));
        cur_req = "R1";
        repeat (2) step();

        // R3: interleaved timestamps across streams
        cur_req = "R3";
        add(0, 1, 10); add(0, 1, 50); add(0, 2, 90);
        add(1, 2, 20); add(1, 3, 40); add(1, 1, 100);
        add(2, 0, 5);  add(2, 4, 70);
        add(3, 5, 30); add(3, 6, 60); add(3, 2, 80);
        drain();

        // R4: equal timestamps, lowest input first
        cur_req = "R4";
        for (int i = NI - 1; i >= 0; i--) add(i, i, 200);
        add(2, 1, 201); add(1, 1, 201);
        drain();

        // R5: single active stream released by the wait counter
        cur_req = "R5";
        add(1, 3, 300); add(1, 3, 310);
        drain();

        // R6: masked type dropped
        cur_req = "R6";
        tmask = ~16'h0008;
        for (int k = 0; k < 8; k++) add(k % NI, k % 6, 400 + 10 * k);
        drain();
        tmask = '1;

        // R7: shield veto per record type
        cur_req = "R7";
        supp_en = 1; vw[1] = 20;
        add(0, 7, 1000); add(1, 1, 1010); add(2, 1, 1030); add(3, 2, 1005);
        drain();
        supp_en = 0; vw[1] = 0;

        // R8: thinning one in three
        cur_req = "R8";
        dsf[2] = 3;
        for (int k = 0; k < 7; k++) add(k % NI, 2, 1500 + 20 * k);
        drain();
        dsf[2] = 1;

        // R9: coincidence gate
        cur_req = "R9";
        cty[0] = 16'h0030; cmul[0] = 2; cwin[0] = 10;
        cty[13] = 16'h0040; cmul[13] = 1; cwin[13] = 0;
        cen = 14'h2001;
        add(0, 4, 2000); add(1, 5, 2005); add(2, 6, 2008); add(3, 4, 2100); add(0, 9, 2103);
        drain();
        cen = '0;

        // R10 and R2: output back-pressure fills the buffers
        cur_req = "R10";
        hold_out = 1;
        for (int k = 0; k < 40; k++) add(k % NI, k % 8, 3000 + 7 * k);
        drain();
        hold_out = 0;
        repeat (2) step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule